// File: doc/BRIEF.md
# Prefixed Opcode Class Decoder

This block sits behind the instruction fetch of an 8-bit accumulator processor. It takes fetched bytes one at a time over a valid/ready handshake. Prefix bytes are absorbed. For every instruction it hands one decoded record to the next pipeline stage. A record holds the prefix that was in force, the opcode byte, a coarse instruction class, the index register the instruction selects, and a flag for prefix/opcode pairs that are not allowed.

The prefix tracker is a two-state machine. ST_OPCODE means no prefix is pending. ST_AFTER_PFX means a prefix byte has been stored and the next byte must be the opcode. It has three named transitions:
- T_TAKE_PFX: ST_OPCODE to ST_AFTER_PFX, taken when a prefix byte arrives.
- T_EMIT_PLAIN: ST_OPCODE to itself, taken when any other byte arrives. A record with prefix 0x00 is emitted.
- T_EMIT_PFX: ST_AFTER_PFX back to ST_OPCODE, taken when any byte arrives. A record is emitted carrying the stored prefix.

Synchronous reset forces ST_OPCODE.

The classifier looks at the low nibble of the opcode first, which gives the legality and kind of each group. It then uses the high nibble to pick the group. A one-entry output slot holds each record until the consumer takes it. While the slot is full and not draining, the block stops accepting input.

Top module: `pfx_opcode_decoder`

## Requirements
- R1: During a cycle with `rst` high, the block returns to ST_OPCODE and empties the output slot. On the cycle after reset, `out_valid` is 0 and `in_ready` is 1. A prefix accepted before the reset does not apply to the first opcode after it.
- R2: In ST_OPCODE, bytes 0x90, 0x91 and 0x92 are prefixes. They are consumed and produce no record. The next record carries that byte in `out_prefix`. A record for an unprefixed opcode carries `out_prefix` = 0x00.
- R3: In ST_AFTER_PFX, the accepted byte is always taken as the opcode, even when it is 0x90, 0x91 or 0x92. Such opcodes fall in row 9 with low nibble 0 to 2 and get class 8 (invalid).
- R4: `out_class` takes these values from the high nibble of the opcode, whatever the low nibble:
  - 0x0 gives class 0 (bit test and branch).
  - 0x1 gives class 1 (bit set/reset).
  - 0x2 gives class 2 (relative jump).
- R5: For high nibbles 0x3 to 0x7, low nibbles 1, 2, 5 and B give class 8 (invalid). Every other low nibble gives class 3 (unary read-modify-write).
- R6: For high nibbles 0xA to 0xF, the class depends on the low nibble:
  - Low nibble C gives class 6 (jump).
  - Low nibble D gives class 7 (call). This includes the relative call 0xAD.
  - Every other low nibble gives class 5 (two-operand ALU or load/store).
  - Opcodes 0xA7, 0xAC and 0xAF are the exceptions and give class 8.
- R7: In row 8, opcodes 0x80, 0x81, 0x83, 0x84, 0x85, 0x86, 0x88, 0x89, 0x8A, 0x8E and 0x8F give class 4 (stack/register/control). Every other row-8 opcode gives class 8.
- R8: In row 9, low nibbles 3 to F give class 4 and low nibbles 0 to 2 give class 8.
- R9: `out_index_y` is 1 exactly when `out_prefix` is 0x90. `out_pfx_err` is 1 in two cases, and in those cases the class is unchanged:
  - The opcode is one of the index-selecting register operations 0x85, 0x89, 0x93, 0x94, 0x96, 0x97 or 0x9F, and the prefix is neither 0x00 nor 0x90.
  - The opcode is 0x95 or 0x9E and the prefix is not 0x00.
- R10: `in_ready` is 1 exactly when the slot is empty or `out_ready` is 1.
  - A byte is taken when `in_valid` and `in_ready` are both 1 at a clock edge. An opcode taken that way has its record valid from the next cycle.
  - While `out_valid` is 1 and `out_ready` is 0, every record field holds still and `in_ready` is 0.
  - Records leave in the order their opcodes arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is valid |
| in_byte | input | 8 | Fetched byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| out_ready | input | 1 | Consumer takes the record this cycle |
| out_valid | output | 1 | Record is valid |
| out_prefix | output | 8 | Prefix in force, 0x00 when none |
| out_opcode | output | 8 | Opcode byte |
| out_class | output | 4 | Instruction class code, 0 to 8 |
| out_index_y | output | 1 | 1 selects index Y, 0 selects index X |
| out_pfx_err | output | 1 | Prefix is not allowed with this opcode |

## Verification
A tracker stuck in or wrongly entering ST_AFTER_PFX shows up at the ports on the very next record. That record either carries the wrong prefix or is missing, because a plain byte was swallowed or a prefix leaked out as an opcode. A drift in the record count is also caught when the expected queue is drained at the end. Classifier faults show as a wrong class or error flag on the first record of the affected opcode. Every opcode is presented under every prefix value, so such a fault appears within one sweep. Slot faults show in the first stalled cycle as a record that changes, or as `in_ready` rising while the consumer is holding back.

// File: rtl/pfxdec_pkg.sv
package pfxdec_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;

    localparam logic [BYTE_W-1:0] PFX_NONE = 8'h00;
    localparam logic [BYTE_W-1:0] PFX_Y    = 8'h90;
    localparam logic [BYTE_W-1:0] PFX_ALT1 = 8'h91;
    localparam logic [BYTE_W-1:0] PFX_ALT2 = 8'h92;

    typedef enum logic [3:0] {
        CLS_BITBR  = 4'd0,
        CLS_BITSET = 4'd1,
        CLS_RELJMP = 4'd2,
        CLS_UNARY  = 4'd3,
        CLS_SYSREG = 4'd4,
        CLS_ALU2   = 4'd5,
        CLS_JUMP   = 4'd6,
        CLS_CALL   = 4'd7,
        CLS_BAD    = 4'd8
    } op_class_e;

    typedef enum logic {
        ST_OPCODE,
        ST_AFTER_PFX
    } trk_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] pfx;
        logic [BYTE_W-1:0] op;
        op_class_e         cls;
        logic              idx_y;
        logic              pfx_err;
    } dec_rec_t;

    function automatic logic is_prefix(input logic [BYTE_W-1:0] b);
        return (b == PFX_Y) || (b == PFX_ALT1) || (b == PFX_ALT2);
    endfunction

endpackage

// File: rtl/pfxdec_tracker.sv
module pfxdec_tracker
    import pfxdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              emit,
    output logic [BYTE_W-1:0] pfx_out,
    output logic              pending
);

    trk_state_e        state, state_n;
    logic [BYTE_W-1:0] held, held_n;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_OPCODE;
            held  <= PFX_NONE;
        end else begin
            state <= state_n;
            held  <= held_n;
        end
    end

    // transitions and outputs
    always_comb begin
        state_n = state;
        held_n  = held;
        emit    = 1'b0;
        pfx_out = PFX_NONE;
        unique case (state)
            ST_OPCODE: begin
                if (take) begin
                    if (is_prefix(byte_in)) begin
                        // T_TAKE_PFX
                        state_n = ST_AFTER_PFX;
                        held_n  = byte_in;
                    end else begin
                        // T_EMIT_PLAIN
                        emit = 1'b1;
                    end
                end
            end
            ST_AFTER_PFX: begin
                pfx_out = held;
                if (take) begin
                    // T_EMIT_PFX: any byte is the opcode here
                    emit    = 1'b1;
                    state_n = ST_OPCODE;
                    held_n  = PFX_NONE;
                end
            end
        endcase
    end

    assign pending = (state == ST_AFTER_PFX);

endmodule

// File: rtl/pfxdec_classify.sv
module pfxdec_classify
    import pfxdec_pkg::*;
(
    input  logic [BYTE_W-1:0] pfx,
    input  logic [BYTE_W-1:0] op,
    output op_class_e         cls,
    output logic              idx_y,
    output logic              pfx_err
);

    logic [NIB_W-1:0] lo, hi;
    assign lo = op[NIB_W-1:0];
    assign hi = op[BYTE_W-1:NIB_W];

    logic      un_ok;     // unary group legal
    logic      stk_ok;    // row 8 legal
    logic      reg_ok;    // row 9 legal
    logic      stk_idx;   // row 8 index-selecting
    logic      reg_idx;   // row 9 index-selecting
    logic      reg_bare;  // row 9, unprefixed only
    logic      a_hole;    // row A exceptions
    op_class_e pair_cls;

    // low nibble first
    always_comb begin
        un_ok    = 1'b1;
        stk_ok   = 1'b1;
        reg_ok   = 1'b1;
        stk_idx  = 1'b0;
        reg_idx  = 1'b0;
        reg_bare = 1'b0;
        a_hole   = 1'b0;
        pair_cls = CLS_ALU2;
        unique case (lo)
            4'h0: begin
                reg_ok = 1'b0;
            end
            4'h1: begin
                un_ok  = 1'b0;
                reg_ok = 1'b0;
            end
            4'h2: begin
                un_ok  = 1'b0;
                stk_ok = 1'b0;
                reg_ok = 1'b0;
            end
            4'h3: begin
                reg_idx = 1'b1;
            end
            4'h4: begin
                reg_idx = 1'b1;
            end
            4'h5: begin
                un_ok    = 1'b0;
                stk_idx  = 1'b1;
                reg_bare = 1'b1;
            end
            4'h6: begin
                reg_idx = 1'b1;
            end
            4'h7: begin
                stk_ok  = 1'b0;
                reg_idx = 1'b1;
                a_hole  = 1'b1;
            end
            4'h8: begin
                un_ok = 1'b1;
            end
            4'h9: begin
                stk_idx = 1'b1;
            end
            4'hA: begin
                un_ok = 1'b1;
            end
            4'hB: begin
                un_ok  = 1'b0;
                stk_ok = 1'b0;
            end
            4'hC: begin
                stk_ok   = 1'b0;
                pair_cls = CLS_JUMP;
                a_hole   = 1'b1;
            end
            4'hD: begin
                stk_ok   = 1'b0;
                pair_cls = CLS_CALL;
            end
            4'hE: begin
                reg_bare = 1'b1;
            end
            4'hF: begin
                reg_idx = 1'b1;
                a_hole  = 1'b1;
            end
            default: begin
                un_ok = 1'b0;
            end
        endcase
    end

    // then the high nibble picks the group
    always_comb begin
        unique case (hi)
            4'h0:                         cls = CLS_BITBR;
            4'h1:                         cls = CLS_BITSET;
            4'h2:                         cls = CLS_RELJMP;
            4'h3, 4'h4, 4'h5, 4'h6, 4'h7: cls = un_ok  ? CLS_UNARY  : CLS_BAD;
            4'h8:                         cls = stk_ok ? CLS_SYSREG : CLS_BAD;
            4'h9:                         cls = reg_ok ? CLS_SYSREG : CLS_BAD;
            4'hA:                         cls = a_hole ? CLS_BAD    : pair_cls;
            default:                      cls = pair_cls;
        endcase
    end

    logic sel_ok, none_ok, idx_here, bare_here;
    assign sel_ok    = (pfx == PFX_NONE) || (pfx == PFX_Y);
    assign none_ok   = (pfx == PFX_NONE);
    assign idx_here  = ((hi == 4'h8) && stk_idx) || ((hi == 4'h9) && reg_idx);
    assign bare_here = (hi == 4'h9) && reg_bare;

    assign pfx_err = (idx_here && !sel_ok) || (bare_here && !none_ok);
    assign idx_y   = (pfx == PFX_Y);

endmodule

// File: rtl/pfxdec_slot.sv
module pfxdec_slot
    import pfxdec_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  dec_rec_t rec_in,
    input  logic     out_ready,
    output logic     out_valid,
    output dec_rec_t rec_out,
    output logic     can_take
);

    assign can_take = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            rec_out   <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            rec_out   <= rec_in;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/pfx_opcode_decoder.sv
module pfx_opcode_decoder
    import pfxdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_prefix,
    output logic [BYTE_W-1:0] out_opcode,
    output logic [3:0]        out_class,
    output logic              out_index_y,
    output logic              out_pfx_err
);

    logic              take, emit, trk_pending;
    logic [BYTE_W-1:0] cur_pfx;
    op_class_e         cls;
    logic              idx_y, pfx_err;
    dec_rec_t          rec_new, rec_q;

    assign take = in_valid && in_ready;

    pfxdec_tracker u_trk (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .byte_in (in_byte),
        .emit    (emit),
        .pfx_out (cur_pfx),
        .pending (trk_pending)
    );

    pfxdec_classify u_cls (
        .pfx     (cur_pfx),
        .op      (in_byte),
        .cls     (cls),
        .idx_y   (idx_y),
        .pfx_err (pfx_err)
    );

    always_comb begin
        rec_new.pfx     = cur_pfx;
        rec_new.op      = in_byte;
        rec_new.cls     = cls;
        rec_new.idx_y   = idx_y;
        rec_new.pfx_err = pfx_err;
    end

    pfxdec_slot u_slot (
        .clk       (clk),
        .rst       (rst),
        .load      (emit),
        .rec_in    (rec_new),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .rec_out   (rec_q),
        .can_take  (in_ready)
    );

    assign out_prefix  = rec_q.pfx;
    assign out_opcode  = rec_q.op;
    assign out_class   = rec_q.cls;
    assign out_index_y = rec_q.idx_y;
    assign out_pfx_err = rec_q.pfx_err;

endmodule

// File: rtl/pfxdec_checker.sv
module pfxdec_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [7:0] in_byte,
    input logic       in_ready,
    input logic       out_ready,
    input logic       out_valid,
    input logic [7:0] out_prefix,
    input logic [7:0] out_opcode,
    input logic [3:0] out_class,
    input logic       out_index_y,
    input logic       out_pfx_err,
    input logic       pending
);

    logic fire, pfx_byte;
    assign fire     = in_valid && in_ready;
    assign pfx_byte = (in_byte == 8'h90) || (in_byte == 8'h91) || (in_byte == 8'h92);

    p_reset_r1: assert property (@(posedge clk) rst |=> !out_valid && !pending);

    p_pfx_swallow_r2: assert property (@(posedge clk) disable iff (rst)
        fire && !pending && pfx_byte |=> !out_valid && pending);

    p_plain_r2: assert property (@(posedge clk) disable iff (rst)
        fire && !pending && !pfx_byte |=> out_valid && out_prefix == 8'h00);

    p_after_pfx_r3: assert property (@(posedge clk) disable iff (rst)
        fire && pending |=> out_valid && !pending && out_opcode == $past(in_byte));

    p_top_rows_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_opcode[7:4] <= 4'h2 |-> out_class == out_opcode[7:4]);

    p_unary_bad_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_opcode[7:4] >= 4'h3 && out_opcode[7:4] <= 4'h7 &&
        (out_opcode[3:0] == 4'h1 || out_opcode[3:0] == 4'h2 ||
         out_opcode[3:0] == 4'h5 || out_opcode[3:0] == 4'hB)
        |-> out_class == 4'd8);

    p_index_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_index_y |-> out_prefix == 8'h90);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid &&
        $stable({out_prefix, out_opcode, out_class, out_index_y, out_pfx_err}));

    p_stall_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);

endmodule

bind pfx_opcode_decoder pfxdec_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_byte     (in_byte),
    .in_ready    (in_ready),
    .out_ready   (out_ready),
    .out_valid   (out_valid),
    .out_prefix  (out_prefix),
    .out_opcode  (out_opcode),
    .out_class   (out_class),
    .out_index_y (out_index_y),
    .out_pfx_err (out_pfx_err),
    .pending     (trk_pending)
);

// File: tb/test_pfx_opcode_decoder.sv
`timescale 1ns/1ps
module test_pfx_opcode_decoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_ready;
    logic       out_ready = 1'b1;
    logic       out_valid;
    logic [7:0] out_prefix, out_opcode;
    logic [3:0] out_class;
    logic       out_index_y, out_pfx_err;

    always #2.5 clk = ~clk;

    pfx_opcode_decoder i_pfx_opcode_decoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .out_ready(out_ready), .out_valid(out_valid),
        .out_prefix(out_prefix), .out_opcode(out_opcode), .out_class(out_class),
        .out_index_y(out_index_y), .out_pfx_err(out_pfx_err)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit rand_ready = 1'b0;
    bit done = 1'b0;

    function automatic logic [3:0] ref_cls(input logic [7:0] o);
        logic [3:0] lo;
        lo = o[3:0];
        if (o < 8'h10) return 4'd0;
        if (o < 8'h20) return 4'd1;
        if (o < 8'h30) return 4'd2;
        if (o < 8'h80) return (lo == 4'h1 || lo == 4'h2 || lo == 4'h5 || lo == 4'hB) ? 4'd8 : 4'd3;
        if (o < 8'h90) return (o inside {8'h80, 8'h81, 8'h83, 8'h84, 8'h85, 8'h86,
                                         8'h88, 8'h89, 8'h8A, 8'h8E, 8'h8F}) ? 4'd4 : 4'd8;
        if (o < 8'hA0) return (lo >= 4'h3) ? 4'd4 : 4'd8;
        if (o inside {8'hA7, 8'hAC, 8'hAF}) return 4'd8;
        if (lo == 4'hC) return 4'd6;
        if (lo == 4'hD) return 4'd7;
        return 4'd5;
    endfunction

    function automatic logic ref_err(input logic [7:0] p, input logic [7:0] o);
        if (o inside {8'h85, 8'h89, 8'h93, 8'h94, 8'h96, 8'h97, 8'h9F})
            return !(p == 8'h00 || p == 8'h90);
        if (o inside {8'h95, 8'h9E})
            return p != 8'h00;
        return 1'b0;
    endfunction

    function automatic string cls_tag(input logic [7:0] o);
        if (o < 8'h30) return "R4";
        if (o < 8'h80) return "R5";
        if (o < 8'h90) return "R7";
        if (o < 8'hA0) return "R8";
        return "R6";
    endfunction

    // expected record queue: {pfx, op}
    logic [15:0] expq [0:255];
    int  qh = 0, qt = 0;
    bit  pend_m = 1'b0;
    logic [7:0] held_m = 8'h00;
    bit  prev_stall = 1'b0;
    logic [21:0] prev_rec;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor and model, away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            pend_m = 1'b0;
            qh = qt;
            prev_stall = 1'b0;
        end else begin
            if (prev_stall) begin
                check(out_valid && {out_prefix, out_opcode, out_class, out_index_y, out_pfx_err} == prev_rec,
                      "R10 hold", {out_valid, out_prefix, out_opcode, out_class, out_index_y, out_pfx_err},
                      {1'b1, prev_rec});
            end
            if (out_valid && !out_ready)
                check(!in_ready, "R10 in_ready during stall", in_ready, 0);
            prev_stall = out_valid && !out_ready;
            prev_rec   = {out_prefix, out_opcode, out_class, out_index_y, out_pfx_err};
            if (out_valid && out_ready) begin
                if (qh == qt) begin
                    check(1'b0, "R10 unexpected record", out_opcode, 0);
                end else begin
                    logic [7:0] ep, eo;
                    {ep, eo} = expq[qh[7:0]];
                    qh++;
                    check(out_prefix == ep && out_opcode == eo,
                          (eo inside {8'h90, 8'h91, 8'h92}) ? "R3 prefix/opcode" : "R2 prefix/opcode",
                          {out_prefix, out_opcode}, {ep, eo});
                    check(out_class == ref_cls(eo), cls_tag(eo), out_class, ref_cls(eo));
                    check(out_index_y == (ep == 8'h90) && out_pfx_err == ref_err(ep, eo),
                          "R9 index/error", {out_index_y, out_pfx_err},
                          {(ep == 8'h90), ref_err(ep, eo)});
                end
            end
            if (in_valid && in_ready) begin
                if (!pend_m && (in_byte inside {8'h90, 8'h91, 8'h92})) begin
                    pend_m = 1'b1;
                    held_m = in_byte;
                end else begin
                    expq[qt[7:0]] = {pend_m ? held_m : 8'h00, in_byte};
                    qt++;
                    pend_m = 1'b0;
                end
            end
        end
    end

    // consumer readiness
    always @(posedge clk) begin
        #1;
        if (!done) out_ready = rand_ready ? ($urandom % 10 < 7) : 1'b1;
        else out_ready = 1'b1;
    end

    task automatic send(input logic [7:0] b);
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic drain;
        int guard = 0;
        while (qh != qt && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    task automatic report;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        report();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(!out_valid && in_ready, "R1 after reset", {out_valid, in_ready}, 2'b01);

        // every opcode unprefixed and under each prefix (R2 R3 R4 R5 R6 R7 R8 R9)
        for (int p = 0; p < 4; p++) begin
            for (int o = 0; o < 256; o++) begin
                if (p != 0) send(8'h8F + 8'(p));
                send(8'(o));
            end
        end
        drain();

        // R1: prefix pending across reset is dropped
        send(8'h92);
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check(!out_valid && in_ready, "R1 reset mid-prefix", {out_valid, in_ready}, 2'b01);
        send(8'h9D);
        drain();

        // random stream with back-pressure (R10)
        rand_ready = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 4 == 0) send(8'h90 + 8'($urandom % 3));
            else send(8'($urandom));
        end
        if (pend_m) send(8'h9D);
        done = 1'b1;
        rand_ready = 1'b0;
        drain();
        check(qh == qt, "R10 all records delivered", qt - qh, 0);
        report();
    end

endmodule